// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is a 32-bit status register that records which reset sources have fired since the flags were last cleared. Seven source inputs each carry a one-cycle (or longer) pulse when their reset event happens: low-power management, window watchdog, independent watchdog, software, power-on/power-down, external pin and brown-out. Each pulse sets the matching flag, and the flag stays set. After boot, software reads the register to learn why the chip restarted, then clears every flag at once by writing a 1 to the remove-flags bit.

The flags are held in a power-reset-only domain, so they survive a system reset. A power reset returns them to the power-up pattern, in which the power-on, pin and brown-out flags are already set. The register also holds a two-bit software control field. That field follows system reset and drives an output. Both reset inputs are asynchronous and active-low. Each one is released through its own synchroniser.

Top module: `rcf_reg`

## Requirements
- R1: While power reset is held, and after it is released, the register reads 0x0E00_0000: bits 27, 26 and 25 are 1 and everything else is 0. Source pulses that arrive while power reset is held are ignored.
- R2: Source input k sets register bit 25+k on the next clock edge. The mapping is k=0 brown-out (bit 25), k=1 pin (26), k=2 power-on (27), k=3 software (28), k=4 independent watchdog (29), k=5 window watchdog (30) and k=6 low-power (31). Several sources may pulse together.
- R3: A flag, once set, stays set until a remove-flags write or a power reset.
- R4: A write with byte enable 3 high and data bit 24 set clears all seven flags on the next edge.
- R5: A source that pulses in the same cycle as a remove-flags write leaves its flag set after that edge. All other flags clear.
- R6: Data bit 24 has no effect when byte enable 3 is low.
- R7: Bits 24 down to 2 always read 0. Writes to the flag bits 31:25 have no effect on them.
- R8: A system reset clears the control field to 0 and leaves the flags unchanged. Source pulses during a system reset still set their flags.
- R9: A write with byte enable 0 high loads data bits 1:0 into the control field, which reads back on bits 1:0 and drives `ctrl_o`. A write with byte enable 0 low leaves the field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_rst_ni | input | 1 | Power reset, asynchronous, active-low |
| sys_rst_ni | input | 1 | System reset, asynchronous, active-low |
| evt_i | input | 7 | Reset-source pulses, bit k maps to register bit 25+k |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high |
| be_i | input | 4 | Byte-lane write enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Register read value |
| ctrl_o | output | 2 | Software control field |

## Verification
A remove-flags write and a source pulse can land on the same edge, and a source pulse can also meet a system reset. The bench provokes both cases directly. In one, it writes the remove-flags bit while a fresh software pulse arrives and other flags are already set. In the other, it pulses a watchdog source while system reset is held low. A behavioural model of the flags and the control field is compared with `rdata_o` and `ctrl_o` on every falling edge. In the collision cases it expects the new source to stay set, the older flags to clear, and the control field to go to zero while the flags are kept.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_FLAGS = 7;
  localparam int FLAG_LSB  = 25;
  localparam int CLR_BIT   = 24;
  localparam int CTRL_W    = 2;
  localparam int SYNC_STG  = 2;
  // power-up pattern: brown-out, pin and power-on flags set
  localparam logic [NUM_FLAGS-1:0] FLAG_PON = 7'b000_0111;
endpackage

// File: rtl/rcf_rst_sync.sv
module rcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign srst_no = chain_q[STAGES-1];
endmodule

// File: rtl/rcf_flag_bank.sv
module rcf_flag_bank #(
  parameter int                       N   = 7,
  parameter logic [N-1:0]             PON = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_en = evt_i[i] | clr_i;
      flag_d  = evt_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q <= PON[i];
      else if (flag_en) flag_q <= flag_d | (flag_q & ~clr_i);
    end

    assign flags_o[i] = flag_q;

    a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flags_o[i]);
    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[i] && !clr_i) |=> flags_o[i]);
    a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !evt_i[i]) |=> !flags_o[i]);
  end
endmodule

// File: rtl/rcf_bus_if.sv
module rcf_bus_if #(
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 7,
  parameter int FLAG_LSB  = 25,
  parameter int CLR_BIT   = 24,
  parameter int CTRL_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [DATA_W/8-1:0]  be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic                 clr_o,
  output logic [CTRL_W-1:0]    ctrl_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam int BE_W     = DATA_W / 8;
  localparam int CLR_LANE = CLR_BIT / 8;

  logic [BE_W-1:0]   lane_wr;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;

  always_comb begin
    lane_wr = '0;
    for (int b = 0; b < BE_W; b++) begin
      lane_wr[b] = rst_ni & req_i & we_i & be_i[b];
    end
    clr_o   = lane_wr[CLR_LANE] & wdata_i[CLR_BIT];
    ctrl_en = lane_wr[0];
    ctrl_d  = wdata_i[CTRL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[FLAG_LSB +: NUM_FLAGS] = flags_i;
    rdata_o[CTRL_W-1:0]            = ctrl_q;
  end

  assign ctrl_o = ctrl_q;

  a_r9_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && be_i[0]) |=> $stable(ctrl_o));
  a_r9_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && be_i[0]) |=> (ctrl_o == $past(wdata_i[CTRL_W-1:0])));
endmodule

// File: rtl/rcf_reg.sv
module rcf_reg
  import rcf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 por_rst_ni,
  input  logic                 sys_rst_ni,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [DATA_W/8-1:0]  be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [CTRL_W-1:0]    ctrl_o
);
  localparam int CLR_LANE = CLR_BIT / 8;

  logic flag_rst_n;
  logic sys_rst_n;
  logic sys_arst_n;
  logic clr;
  logic [NUM_FLAGS-1:0] flags;

  // system domain is also cleared by power reset
  assign sys_arst_n = por_rst_ni & sys_rst_ni;

  rcf_rst_sync #(.STAGES(SYNC_STG)) u_por_sync (
    .clk_i  (clk_i),
    .arst_ni(por_rst_ni),
    .srst_no(flag_rst_n)
  );

  rcf_rst_sync #(.STAGES(SYNC_STG)) u_sys_sync (
    .clk_i  (clk_i),
    .arst_ni(sys_arst_n),
    .srst_no(sys_rst_n)
  );

  rcf_flag_bank #(.N(NUM_FLAGS), .PON(FLAG_PON)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (flag_rst_n),
    .evt_i  (evt_i),
    .clr_i  (clr),
    .flags_o(flags)
  );

  rcf_bus_if #(
    .DATA_W   (DATA_W),
    .NUM_FLAGS(NUM_FLAGS),
    .FLAG_LSB (FLAG_LSB),
    .CLR_BIT  (CLR_BIT),
    .CTRL_W   (CTRL_W)
  ) u_bus (
    .clk_i  (clk_i),
    .rst_ni (sys_rst_n),
    .req_i  (req_i),
    .we_i   (we_i),
    .be_i   (be_i),
    .wdata_i(wdata_i),
    .flags_i(flags),
    .clr_o  (clr),
    .ctrl_o (ctrl_o),
    .rdata_o(rdata_o)
  );

  a_r6_lane_gates_clear: assert property (@(posedge clk_i) disable iff (!flag_rst_n)
    ((evt_i == '0) && !(req_i && we_i && be_i[CLR_LANE]))
      |=> (rdata_o[DATA_W-1:FLAG_LSB] == $past(rdata_o[DATA_W-1:FLAG_LSB])));
  a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!flag_rst_n)
    rdata_o[CLR_BIT:CTRL_W] == '0);
  a_r8_sys_keeps_flags: assert property (@(posedge clk_i) disable iff (!flag_rst_n)
    (!sys_rst_n && evt_i == '0) |=> $stable(flags));
endmodule

// File: tb/tb_rcf_reg.sv
module tb_rcf_reg;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_n = 1'b1;
  logic [6:0]  evt = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ctrl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [6:0] m_flags;
  logic [1:0] m_ctrl;
  bit         in_por;
  bit         in_sys;
  string      tag;

  always #5ns clk = ~clk;

  rcf_reg dut (
    .clk_i(clk), .por_rst_ni(por_n), .sys_rst_ni(sys_n), .evt_i(evt),
    .req_i(req), .we_i(we), .be_i(be), .wdata_i(wdata),
    .rdata_o(rdata), .ctrl_o(ctrl)
  );

  task automatic compare();
    logic [31:0] exp;
    exp = {m_flags, 25'd0} | {30'd0, m_ctrl};
    n_cmp++;
    if (rdata !== exp || ctrl !== m_ctrl) begin
      n_bad++;
      $display("FAIL %s: rdata=%h ctrl=%b expected rdata=%h ctrl=%b",
               tag, rdata, ctrl, exp, m_ctrl);
    end
  endtask

  // one clock: compare at falling edge, drive, update model after rising edge
  task automatic cyc(input logic [6:0] e, input logic w, input logic [3:0] b,
                     input logic [31:0] d);
    @(negedge clk);
    compare();
    evt = e; req = w; we = w; be = b; wdata = d;
    @(posedge clk);
    #1;
    if (!in_por) begin
      if (w && b[3] && d[24] && !in_sys) m_flags = e;
      else                               m_flags = m_flags | e;
      if (w && b[0] && !in_sys) m_ctrl = d[1:0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 1'b0, '0, '0);
  endtask

  task automatic power_reset();
    @(negedge clk);
    por_n = 1'b0; in_por = 1'b1;
    m_flags = 7'b000_0111; m_ctrl = '0;
    tag = "R1";
    cyc(7'h7f, 1'b0, '0, '0);   // pulses ignored while held
    idle(2);
    @(negedge clk);
    por_n = 1'b1; in_por = 1'b0;
    idle(3);
  endtask

  initial begin
    in_por = 1'b1; in_sys = 1'b0;
    m_flags = 7'b000_0111; m_ctrl = '0;
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_n = 1'b1; in_por = 1'b0;
    idle(3);

    tag = "R9";
    cyc('0, 1'b1, 4'b0001, 32'h0000_0002);
    cyc('0, 1'b1, 4'b0001, 32'h0000_0001);
    cyc('0, 1'b1, 4'b1110, 32'h0000_0003);   // lane 0 off, no load
    idle(1);

    tag = "R4";
    cyc('0, 1'b1, 4'b1000, 32'h0100_0000);
    idle(1);

    tag = "R2";
    for (int k = 0; k < 7; k++) begin
      cyc(7'(1 << k), 1'b0, '0, '0);
      idle(1);
      cyc('0, 1'b1, 4'b1000, 32'h0100_0000);
    end
    cyc(7'b101_0010, 1'b0, '0, '0);
    tag = "R3";
    idle(4);

    tag = "R6";
    cyc('0, 1'b1, 4'b0111, 32'h0100_0000);
    cyc('0, 1'b1, 4'b0110, 32'hffff_ffff);
    idle(1);

    tag = "R7";
    cyc('0, 1'b1, 4'b1000, 32'hfe00_0000);
    cyc('0, 1'b1, 4'b1111, 32'h00ff_fffc);
    idle(1);

    tag = "R5";
    cyc(7'b000_1000, 1'b1, 4'b1000, 32'h0100_0000);
    idle(2);
    cyc(7'b000_1000, 1'b0, '0, '0);
    cyc(7'b000_1000, 1'b1, 4'b1001, 32'h0100_0003);
    idle(1);

    tag = "R8";
    cyc('0, 1'b1, 4'b0001, 32'h0000_0003);
    cyc(7'b010_0000, 1'b0, '0, '0);
    @(negedge clk);
    sys_n = 1'b0; in_sys = 1'b1; m_ctrl = '0;
    cyc(7'b001_0000, 1'b0, '0, '0);   // source pulse during system reset
    cyc('0, 1'b1, 4'b1001, 32'h0100_0003); // write ignored while held
    idle(1);
    @(negedge clk);
    sys_n = 1'b1; in_sys = 1'b0;
    idle(3);

    tag = "R1";
    cyc(7'b110_1000, 1'b1, 4'b0001, 32'h0000_0002);
    idle(1);
    power_reset();
    idle(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #50us;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule